// File: doc/BRIEF.md
# Serial Message CRC-16 Engine

This block builds the 16-bit cyclic redundancy check used by binary-mode serial frames. The check runs one bit per clock over a reflected polynomial. A frame is started by pulsing `clear_i`, which presets the checksum register to all ones. Each message byte then enters on a valid/ready stream port. The current checksum is always visible, both as a 16-bit word and split into the byte that is sent first (low) and the byte that is sent second (high).

On the receive side the same engine also checks a frame. The received data bytes are fed in first. The two received check bytes follow as ordinary data, low byte first. When the frame is intact the register then holds zero, and `residue_ok_o` goes high once the engine is idle.

The input stream does not hold data back for the sender. `in_ready_o` is high only while the engine is idle. A beat is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high and `clear_i` is low. If a beat is offered while `in_ready_o` is low, it is dropped instead of stalled, and a sticky overrun flag records the loss. The sender must therefore wait for ready before it presents a byte.

Top module: `crc16_engine`

## Requirements
- R1: After reset, and on the edge after a `clear_i` pulse, `crc_o` is FFFFH, `overrun_o` is 0 and `in_ready_o` is 1. `clear_i` wins over a beat offered in the same cycle; that beat is neither absorbed nor counted as an overrun.
- R2: For each accepted byte, the byte is XORed into bits 7:0 of the register. Then eight steps run. In each step the register shifts right by one with a zero into bit 15, and the result is XORed with A001H when the bit shifted out was 1.
- R3: After a byte is accepted, `in_ready_o` is low and `busy_o` is high for exactly 7 cycles. The next byte can be accepted on the 8th edge after the previous one.
- R4: `crc_lo_o` is bits 7:0 of the checksum and `crc_hi_o` is bits 15:8. For the message 01,03,21,02,00,02, the low byte is 6FH and the high byte is F7H.
- R5: A beat offered while `in_ready_o` is low leaves the checksum unchanged and sets `overrun_o`. `overrun_o` stays set until `clear_i` or reset.
- R6: After the data bytes and then their checksum (low byte, then high byte) are fed in, `crc_o` is 0000H. At that point `residue_ok_o` is 1 while the engine is idle. For a corrupted frame it is 0.
- R7: While idle, with no beat offered and no clear, `crc_o` holds its value. A `clear_i` during the eight steps aborts the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start of a new frame: presets the register and clears overrun |
| in_valid_i | input | 1 | Byte beat valid |
| in_data_i | input | 8 | Byte beat data |
| in_ready_o | output | 1 | Engine idle and able to take a byte |
| busy_o | output | 1 | Bit steps in progress |
| crc_o | output | 16 | Running checksum |
| crc_lo_o | output | 8 | Check byte sent first |
| crc_hi_o | output | 8 | Check byte sent second |
| residue_ok_o | output | 1 | Idle with zero residue (frame passed) |
| overrun_o | output | 1 | Sticky: a beat was dropped while busy |

## Verification
Two situations are hard to reach from the ports: a beat that collides with the bit steps, and a clear that lands in the middle of them. To hit both, the bench drives a second beat a fixed number of cycles after an accepted one. It then checks that the checksum still equals the arithmetic value of the accepted bytes alone. A sweep over all 256 single-byte frames, each followed by its own computed checksum, covers every combination of shift-out bits in the check mode.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W = 16;
  typedef logic [CRC_W-1:0] crc_t;
  localparam crc_t POLY_REFL = 16'hA001;
  localparam crc_t PRESET    = 16'hFFFF;

  // one reflected shift step: shift right, fold polynomial if a one fell out
  function automatic crc_t crc_shift1(input crc_t c, input crc_t poly);
    crc_t s;
    s = {1'b0, c[CRC_W-1:1]};
    if (c[0]) s = s ^ poly;
    return s;
  endfunction
endpackage

// File: rtl/crc16_sequencer.sv
module crc16_sequencer #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic accept_o,
  output logic step_o,
  output logic busy_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] REMAIN = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] left_q;

  assign busy_o     = (left_q != '0);
  assign in_ready_o = ~busy_o;
  assign accept_o   = in_valid_i & in_ready_o & ~clear_i;
  assign step_o     = busy_o & ~clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        left_q <= '0;
    else if (clear_i)  left_q <= '0;
    else if (accept_o) left_q <= REMAIN;
    else if (busy_o)   left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int   DATA_W = 8,
  parameter crc_t POLY   = POLY_REFL,
  parameter crc_t INIT   = PRESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] data_i,
  output crc_t              crc_o
);
  crc_t crc_q;
  crc_t folded;

  assign folded = crc_q ^ crc_t'(data_i);
  assign crc_o  = crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= INIT;
    else if (clear_i) crc_q <= INIT;
    else if (load_i)  crc_q <= crc_shift1(folded, POLY);
    else if (step_i)  crc_q <= crc_shift1(crc_q, POLY);
  end
endmodule

// File: rtl/crc16_overrun.sv
module crc16_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic in_valid_i,
  input  logic in_ready_i,
  output logic overrun_o
);
  logic flag_q;
  assign overrun_o = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag_q <= 1'b0;
    else if (clear_i)                 flag_q <= 1'b0;
    else if (in_valid_i && !in_ready_i) flag_q <= 1'b1;
  end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter int   DATA_W = 8,
  parameter crc_t POLY   = POLY_REFL,
  parameter crc_t INIT   = PRESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              busy_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic [7:0]        crc_lo_o,
  output logic [7:0]        crc_hi_o,
  output logic              residue_ok_o,
  output logic              overrun_o
);
  logic accept, step;
  crc_t crc;

  crc16_sequencer #(.DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .accept_o(accept), .step_o(step), .busy_o(busy_o)
  );

  crc16_datapath #(.DATA_W(DATA_W), .POLY(POLY), .INIT(INIT)) dp_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_i(accept),
    .step_i(step), .data_i(in_data_i), .crc_o(crc)
  );

  crc16_overrun ovr_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .in_valid_i(in_valid_i),
    .in_ready_i(in_ready_o), .overrun_o(overrun_o)
  );

  assign crc_o        = crc;
  assign crc_lo_o     = crc[7:0];
  assign crc_hi_o     = crc[15:8];
  assign residue_ok_o = in_ready_o & (crc == '0);
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clear_i,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        busy_o,
  input logic [15:0] crc_o,
  input logic        overrun_o
);
  // R1
  clear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (crc_o == 16'hFFFF) && !overrun_o && in_ready_o);
  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && !clear_i) |=> busy_o && !in_ready_o);
  // R5
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !in_ready_o && !clear_i) |=> overrun_o);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !clear_i) |=> overrun_o);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready_o && !in_valid_i && !clear_i) |=> $stable(crc_o));
endmodule

bind crc16_engine crc16_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .busy_o(busy_o), .crc_o(crc_o), .overrun_o(overrun_o)
);

// File: tb/crc16_engine_tb_top.sv
module crc16_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, vld = 1'b0;
  logic [7:0] dat = '0;
  logic rdy, busy, ok, ovr;
  logic [15:0] crc;
  logic [7:0] lo, hi;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_engine dut_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .in_valid_i(vld), .in_data_i(dat),
    .in_ready_o(rdy), .busy_o(busy), .crc_o(crc), .crc_lo_o(lo), .crc_hi_o(hi),
    .residue_ok_o(ok), .overrun_o(ovr)
  );

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clear = 1'b1; @(negedge clk); clear = 1'b0; @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    while (!rdy) @(negedge clk);
    vld = 1'b1; dat = b; @(negedge clk); vld = 1'b0;
  endtask

  task automatic idle();
    while (!rdy) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] e;
    int cnt;
    logic [7:0] msg [6] = '{8'h01, 8'h03, 8'h21, 8'h02, 8'h00, 8'h02};
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    // R1 reset state
    check("R1 reset crc", crc, 16'hFFFF);
    check("R1 reset flags", {14'b0, ovr, rdy}, 16'h0001);

    // R4 known vector, R2 arithmetic
    e = 16'hFFFF;
    foreach (msg[i]) begin send(msg[i]); e = ref_byte(e, msg[i]); end
    idle();
    check("R4 low byte", {8'h00, lo}, 16'h006F);
    check("R4 high byte", {8'h00, hi}, 16'h00F7);
    check("R2 vector crc", crc, e);
    check("R6 ok before check bytes", {15'b0, ok}, 16'h0000);
    send(8'h6F); send(8'hF7); idle();
    check("R6 residue zero", crc, 16'h0000);
    check("R6 ok flag", {15'b0, ok}, 16'h0001);

    // R3 busy window
    do_clear();
    send(8'h5A);
    cnt = 0;
    while (!rdy) begin
      if (!busy) begin n_bad++; $display("FAIL R3 busy low while not ready actual=0 expected=1"); end
      cnt++; @(negedge clk);
    end
    check("R3 busy cycles", 16'(cnt), 16'd7);

    // R5 dropped beat during steps
    do_clear();
    send(8'h01);
    @(negedge clk); @(negedge clk);
    vld = 1'b1; dat = 8'hAA; @(negedge clk); vld = 1'b0;
    idle();
    check("R5 crc ignores dropped beat", crc, ref_byte(16'hFFFF, 8'h01));
    check("R5 overrun set", {15'b0, ovr}, 16'h0001);
    send(8'h10); idle();
    check("R5 overrun sticky", {15'b0, ovr}, 16'h0001);
    // R7 idle hold
    e = crc;
    repeat (5) @(negedge clk);
    check("R7 idle hold", crc, e);
    // R1 clear
    do_clear();
    check("R1 clear crc", crc, 16'hFFFF);
    check("R1 clear overrun", {15'b0, ovr}, 16'h0000);

    // R1 clear with beat in same cycle
    clear = 1'b1; vld = 1'b1; dat = 8'h33; @(negedge clk);
    clear = 1'b0; vld = 1'b0;
    check("R1 clear beats beat crc", crc, 16'hFFFF);
    check("R1 clear beats beat flags", {14'b0, ovr, rdy}, 16'h0001);

    // R7 clear aborts mid-steps
    send(8'hC3); @(negedge clk); @(negedge clk);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    check("R7 abort crc", crc, 16'hFFFF);
    check("R7 abort ready", {15'b0, rdy}, 16'h0001);

    // R6 corrupted frame
    do_clear();
    send(8'h01); send(8'h03); send(8'h6F); send(8'hF6); idle();
    check("R6 bad frame ok", {15'b0, ok}, 16'h0000);

    // R2/R6 sweep over every single-byte frame
    for (int b = 0; b < 256; b++) begin
      do_clear();
      send(8'(b)); idle();
      e = ref_byte(16'hFFFF, 8'(b));
      check("R2 sweep crc", crc, e);
      send(e[7:0]); send(e[15:8]); idle();
      check("R6 sweep ok", {15'b0, ok}, 16'h0001);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule